// File: doc/BRIEF.md
# SPI Write/Read Transfer Engine

This block carries out a single SPI operation for a command controller. Once the controller has decoded the operation opcode (0x13), it pulses `start`. The engine then takes two 24-bit lengths from the host input byte stream: first the number of bytes to write, then the number of bytes to read. It drives a mode-0 SPI bus and returns an acknowledge byte and the bytes it reads on the host output byte stream. Both host streams use valid/ready handshakes. A beat moves on any rising clock edge where both valid and ready are high. `in_ready` is high only while the engine is waiting for a length byte or a write byte. When it is low, the sender holds its byte. The engine holds `out_valid` and `out_data` steady until the receiver takes the beat. While either side stalls, the SPI clock stops between bytes.

Two orderings are available. In write-then-read order, every write byte goes out first. The acknowledge byte follows, and then the read bytes are clocked in. In simultaneous order, the acknowledge byte comes first. The engine then clocks as many bytes as the larger of the two lengths. It sends write bytes while they last and zero bytes after that, and it forwards only the first read-length bytes it captures. With automatic select on, the chosen active-low select line frames the whole operation. With automatic select off, every select output stays high so that the controller can drive the select line itself.

Top module: `spi_xfer_engine`

## Requirements
- R1: After `start`, the engine takes six bytes from the input stream: the write length and then the read length, each three bytes with the least significant byte first.
- R2: With `full_duplex` low, all write bytes are shifted out first. The acknowledge byte 0x06 is then offered, and after it the engine clocks in read-length bytes while MOSI stays low, forwarding each byte in order.
- R3: With `full_duplex` high, the acknowledge byte 0x06 is offered before the first SCK edge. The engine then clocks max(write length, read length) bytes, sends 0x00 once the write bytes are used up, and drops captured bytes beyond the read length.
- R4: The bus runs in mode 0, MSB first. SCK idles low, MISO is sampled on the rising edge and MOSI changes on the falling edge.
- R5: Each SCK high phase and each SCK low phase inside a byte lasts `clk_div`+1 clock cycles.
- R6: With `auto_cs` high, only `cs_n[cs_sel]` goes low, and it stays low for the whole operation. At least one SCK half-period passes between its falling edge and the first SCK rise, and again between the last SCK fall and its rising edge. Select lines change only while SCK is low.
- R7: With `auto_cs` low, every `cs_n` line stays high during the operation.
- R8: `in_ready` is low whenever the engine is not taking a byte. An offered output beat stays valid with stable data until it is accepted.
- R9: When both lengths are zero, SCK makes no edge, but the acknowledge byte is still sent.
- R10: After reset, `busy`, `done`, `sck`, `mosi`, `in_ready` and `out_valid` are low and all `cs_n` lines are high. At the end of each operation `done` pulses for one cycle, with `busy` already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| full_duplex | input | 1 | 1 = simultaneous order, 0 = write-then-read; sampled at start |
| auto_cs | input | 1 | 1 = engine drives the chosen select line; sampled at start |
| cs_sel | input | CS_W | Index of the select line; sampled at start |
| clk_div | input | DIV_W | SCK half-period minus one, in clock cycles |
| in_valid | input | 1 | Host input byte valid |
| in_data | input | 8 | Host input byte |
| in_ready | output | 1 | Engine takes the input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Acknowledge or read byte |
| out_ready | input | 1 | Host takes the output byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| cs_n | output | NUM_CS | Active-low select lines |

## Verification
The bench builds the engine with four select lines and a 4-bit divider. This lets it reach the top select index and several half-period settings (1, 2, 3 and 4 cycles) while runs stay short. With a 24-bit length field, a 258-byte write exercises the middle length byte, so a misordered length byte shows up as a wrong clock count. A bus slave model with a known response pattern, together with a stalling output receiver, exercises back-pressure in both orderings.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int          XFER_LEN_W = 24;
  localparam logic [7:0]  XFER_ACK   = 8'h06;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LEN,
    ST_ACK,
    ST_CSON,
    ST_SETUP,
    ST_NEXT,
    ST_FETCH,
    ST_SHIFT,
    ST_PUSH,
    ST_HOLD,
    ST_FIN
  } xfer_state_e;
endpackage

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [7:0]       tx_byte,
  input  logic [DIV_W-1:0] half_div,
  output logic [7:0]       rx_byte,
  output logic             rx_done,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);
  logic             active;
  logic [7:0]       tx_sh;
  logic [7:0]       rx_sh;
  logic [2:0]       bit_n;
  logic [DIV_W-1:0] tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      bit_n   <= '0;
      tick    <= '0;
      sck     <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (go && !active) begin
        active <= 1'b1;
        tx_sh  <= tx_byte;
        bit_n  <= '0;
        tick   <= '0;
        sck    <= 1'b0;
      end else if (active) begin
        if (tick == half_div) begin
          tick <= '0;
          if (!sck) begin
            sck   <= 1'b1;
            rx_sh <= {rx_sh[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bit_n == 3'd7) begin
              active  <= 1'b0;
              rx_done <= 1'b1;
            end else begin
              bit_n <= bit_n + 3'd1;
              tx_sh <= {tx_sh[6:0], 1'b0};
            end
          end
        end else begin
          tick <= tick + 1'b1;
        end
      end
    end
  end

  assign mosi    = active & tx_sh[7];
  assign rx_byte = rx_sh;
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             full_duplex,
  input  logic             auto_cs,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready,
  output logic             sh_go,
  output logic [7:0]       sh_tx,
  input  logic [7:0]       sh_rx,
  input  logic             sh_done,
  output logic             cs_act,
  output logic             busy,
  output logic             done
);
  localparam int LB_W = 2 * XFER_LEN_W - 8;

  xfer_state_e           st;
  logic [2:0]            lcnt;
  logic [LB_W-1:0]       lenbuf;
  logic [XFER_LEN_W-1:0] wrem;
  logic [XFER_LEN_W-1:0] rrem;
  logic                  fd_q;
  logic                  auto_q;
  logic                  ack_done;
  logic [DIV_W-1:0]      tcnt;
  logic [7:0]            rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      lcnt     <= '0;
      lenbuf   <= '0;
      wrem     <= '0;
      rrem     <= '0;
      fd_q     <= 1'b0;
      auto_q   <= 1'b0;
      ack_done <= 1'b0;
      tcnt     <= '0;
      rx_q     <= '0;
      sh_go    <= 1'b0;
      sh_tx    <= '0;
      cs_act   <= 1'b0;
      done     <= 1'b0;
    end else begin
      sh_go <= 1'b0;
      done  <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          fd_q     <= full_duplex;
          auto_q   <= auto_cs;
          lcnt     <= '0;
          ack_done <= 1'b0;
          st       <= ST_LEN;
        end
        ST_LEN: if (in_valid) begin
          lenbuf <= {in_data, lenbuf[LB_W-1:8]};
          lcnt   <= lcnt + 3'd1;
          if (lcnt == 3'd5) begin
            wrem <= lenbuf[XFER_LEN_W-1:0];
            rrem <= {in_data, lenbuf[LB_W-1:XFER_LEN_W]};
            st   <= fd_q ? ST_ACK : ST_CSON;
          end
        end
        ST_ACK: if (out_ready) begin
          ack_done <= 1'b1;
          st       <= fd_q ? ST_CSON : ST_NEXT;
        end
        ST_CSON: begin
          cs_act <= auto_q;
          tcnt   <= '0;
          st     <= ST_SETUP;
        end
        ST_SETUP: begin
          if (tcnt == clk_div) st <= ST_NEXT;
          else                 tcnt <= tcnt + 1'b1;
        end
        ST_NEXT: begin
          if (wrem != '0) begin
            st <= ST_FETCH;
          end else if (!ack_done) begin
            st <= ST_ACK;
          end else if (rrem != '0) begin
            sh_go <= 1'b1;
            sh_tx <= 8'h00;
            st    <= ST_SHIFT;
          end else begin
            tcnt <= '0;
            st   <= ST_HOLD;
          end
        end
        ST_FETCH: if (in_valid) begin
          sh_go <= 1'b1;
          sh_tx <= in_data;
          wrem  <= wrem - XFER_LEN_W'(1);
          st    <= ST_SHIFT;
        end
        ST_SHIFT: if (sh_done) begin
          if (ack_done && rrem != '0) begin
            rx_q <= sh_rx;
            st   <= ST_PUSH;
          end else begin
            st <= ST_NEXT;
          end
        end
        ST_PUSH: if (out_ready) begin
          rrem <= rrem - XFER_LEN_W'(1);
          st   <= ST_NEXT;
        end
        ST_HOLD: begin
          if (tcnt == clk_div) begin
            cs_act <= 1'b0;
            st     <= ST_FIN;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_FIN: begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (st == ST_LEN) || (st == ST_FETCH);
  assign out_valid = (st == ST_ACK) || (st == ST_PUSH);
  assign out_data  = (st == ST_ACK) ? XFER_ACK : rx_q;
  assign busy      = (st != ST_IDLE);
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine #(
  parameter int NUM_CS = 4,
  parameter int DIV_W  = 8,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              full_duplex,
  input  logic              auto_cs,
  input  logic [CS_W-1:0]   cs_sel,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic              busy,
  output logic              done,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);
  logic            sh_go;
  logic [7:0]      sh_tx;
  logic [7:0]      sh_rx;
  logic            sh_done;
  logic            cs_act;
  logic [CS_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sel_q <= '0;
    else if (start && !busy) sel_q <= cs_sel;
  end

  spi_xfer_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .full_duplex(full_duplex),
    .auto_cs(auto_cs), .clk_div(clk_div),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .sh_go(sh_go), .sh_tx(sh_tx), .sh_rx(sh_rx), .sh_done(sh_done),
    .cs_act(cs_act), .busy(busy), .done(done)
  );

  spi_bit_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(sh_go), .tx_byte(sh_tx), .half_div(clk_div),
    .rx_byte(sh_rx), .rx_done(sh_done), .sck(sck), .mosi(mosi), .miso(miso)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = ~(cs_act && (sel_q == CS_W'(i)));
  end
endmodule

// File: rtl/spi_xfer_chk.sv
module spi_xfer_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              sck,
  input logic [NUM_CS-1:0] cs_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data
);
  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  // R6
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R6
  cs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(&cs_n) || $fell(&cs_n)) |-> !sck);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind spi_xfer_engine spi_xfer_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sck(sck),
  .cs_n(cs_n), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/tb_spi_xfer_engine.sv
module tb_spi_xfer_engine;
  localparam int NUM_CS = 4;
  localparam int DIV_W  = 4;
  localparam int CS_W   = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              full_duplex = 1'b0;
  logic              auto_cs = 1'b0;
  logic [CS_W-1:0]   cs_sel = '0;
  logic [DIV_W-1:0]  clk_div = '0;
  logic              in_valid = 1'b0;
  logic [7:0]        in_data = '0;
  logic              in_ready;
  logic              out_valid;
  logic [7:0]        out_data;
  logic              out_ready = 1'b0;
  logic              busy;
  logic              done;
  logic              sck;
  logic              mosi;
  logic              miso = 1'b0;
  logic [NUM_CS-1:0] cs_n;
  wire               cs_all_hi = &cs_n;

  spi_xfer_engine #(.NUM_CS(NUM_CS), .DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .full_duplex(full_duplex),
    .auto_cs(auto_cs), .cs_sel(cs_sel), .clk_div(clk_div),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .busy(busy), .done(done), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- bus slave model ----------------
  logic [7:0] slv_rx[$];
  logic [7:0] slv_sh;
  int slv_bit, slv_idx, rises;
  time cs_fall_t, cs_rise_t, first_rise_t, last_fall_t, rise_t;
  int hi_bad, lo_bad, half_exp;
  logic [NUM_CS-1:0] cs_seen_low;

  function automatic logic [7:0] resp(input int i);
    return 8'hA5 ^ 8'(i * 19);
  endfunction

  function automatic logic resp_bit(input int i, input int b);
    logic [7:0] v;
    v = resp(i);
    return v[7-b];
  endfunction

  function automatic logic [7:0] wbyte(input int i);
    return 8'(8'h3C + i * 7);
  endfunction

  always @(posedge sck) begin
    if (rises == 0) first_rise_t = $time;
    else if (($time - last_fall_t) != time'(half_exp * 8) && slv_bit != 0) lo_bad++;
    rise_t = $time;
    rises++;
    slv_sh = {slv_sh[6:0], mosi};
    slv_bit++;
    if (slv_bit == 8) begin
      slv_rx.push_back(slv_sh);
      slv_bit = 0;
      slv_idx++;
    end
  end

  always @(negedge sck) begin
    if (($time - rise_t) != time'(half_exp * 8)) hi_bad++;
    last_fall_t = $time;
    miso = resp_bit(slv_idx, slv_bit);
  end

  always @(negedge cs_all_hi) cs_fall_t = $time;
  always @(posedge cs_all_hi) cs_rise_t = $time;
  always @(cs_n) cs_seen_low = cs_seen_low | ~cs_n;

  task automatic slave_reset();
    slv_rx.delete();
    slv_bit = 0; slv_idx = 0; rises = 0;
    hi_bad = 0; lo_bad = 0;
    cs_seen_low = '0;
    miso = resp_bit(0, 0);
  endtask

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [7:0] b;
    bit         is_ack;
    int         rises;
    string      req;
  } item_t;
  item_t exp_q[$];
  bit    rdy_stall = 1'b0;
  int    rcyc = 0;

  always @(negedge clk) begin
    rcyc++;
    out_ready = rdy_stall ? ((rcyc % 3) == 0) : 1'b1;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected output byte", out_data, -1);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(out_data == it.b, it.req, "output byte", out_data, it.b);
        if (it.is_ack)
          chk(rises == it.rises, it.req, "SCK rises before ack", rises, it.rises);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_op(input bit fd, input bit au, input int sel, input int div,
                        input int wl, input int rl, input bit stall);
    item_t it;
    int n;
    string rq;
    slave_reset();
    half_exp  = div + 1;
    clk_div   = DIV_W'(div);
    rdy_stall = stall;
    rq = fd ? "R3" : "R2";
    it.b = 8'h06; it.is_ack = 1'b1; it.rises = fd ? 0 : 8 * wl; it.req = rq;
    exp_q.push_back(it);
    for (int i = 0; i < rl; i++) begin
      it.b = resp(fd ? i : wl + i); it.is_ack = 1'b0; it.rises = 0; it.req = rq;
      exp_q.push_back(it);
    end
    @(negedge clk);
    start = 1'b1; full_duplex = fd; auto_cs = au; cs_sel = CS_W'(sel);
    @(negedge clk);
    start = 1'b0;
    // R1: lengths least significant byte first, write length before read length
    send(8'(wl)); send(8'(wl >> 8)); send(8'(wl >> 16));
    send(8'(rl)); send(8'(rl >> 8)); send(8'(rl >> 16));
    for (int i = 0; i < wl; i++) send(wbyte(i));
    while (!done) @(negedge clk);
    n = fd ? ((wl > rl) ? wl : rl) : wl + rl;
    chk(busy == 1'b0, "R10", "busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done single pulse", done, 0);
    chk(in_ready == 1'b0, "R8", "in_ready low when idle", in_ready, 0);
    chk(exp_q.size() == 0, rq, "outputs left undelivered", exp_q.size(), 0);
    // R1 / R3 / R9: clock count follows the parsed lengths
    chk(rises == 8 * n, "R1", "SCK rising edges", rises, 8 * n);
    chk(slv_rx.size() == n, "R3", "bytes seen by slave", slv_rx.size(), n);
    for (int i = 0; i < n && i < slv_rx.size(); i++) begin
      logic [7:0] e;
      e = (i < wl) ? wbyte(i) : 8'h00;
      chk(slv_rx[i] == e, "R4", "MOSI byte", slv_rx[i], e);
    end
    chk(hi_bad == 0 && lo_bad == 0, "R5", "SCK half-period mismatches",
        hi_bad + lo_bad, 0);
    chk(cs_n == '1, "R6", "select lines high after operation", cs_n, 4'hF);
    if (au) begin
      chk(cs_seen_low == NUM_CS'(1 << sel), "R6", "select lines that went low",
          cs_seen_low, 1 << sel);
      if (n > 0) begin
        chk(first_rise_t - cs_fall_t >= time'(half_exp * 8), "R6", "setup ns",
            first_rise_t - cs_fall_t, half_exp * 8);
        chk(cs_rise_t - last_fall_t >= time'(half_exp * 8), "R6", "hold ns",
            cs_rise_t - last_fall_t, half_exp * 8);
      end
    end else begin
      chk(cs_seen_low == '0, "R7", "select lines low in forced mode", cs_seen_low, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    slave_reset();
    half_exp = 1;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(busy == 0 && done == 0, "R10", "busy/done at reset", {busy, done}, 0);
    chk(sck == 0 && mosi == 0, "R10", "sck/mosi at reset", {sck, mosi}, 0);
    chk(cs_n == '1, "R10", "cs_n at reset", cs_n, 4'hF);
    chk(in_ready == 0 && out_valid == 0, "R10", "handshakes at reset",
        {in_ready, out_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2: write-then-read
    run_op(1'b0, 1'b1, 0, 2, 3, 2, 1'b0);
    // R3: simultaneous, write longer than read (excess reads dropped)
    run_op(1'b1, 1'b1, 2, 0, 3, 1, 1'b1);
    // R3: simultaneous, read longer than write (zero padding)
    run_op(1'b1, 1'b1, 1, 1, 1, 3, 1'b1);
    // R9: zero lengths, simultaneous
    run_op(1'b1, 1'b1, 3, 0, 0, 0, 1'b0);
    // R7: forced select, write-then-read with output stalls
    run_op(1'b0, 1'b0, 1, 1, 2, 2, 1'b1);
    // R1: middle length byte in use
    run_op(1'b0, 1'b1, 0, 0, 258, 1, 1'b0);
    // R9: zero lengths, write-then-read
    run_op(1'b0, 1'b1, 2, 3, 0, 0, 1'b0);
    // R2: read only, slow clock
    run_op(1'b0, 1'b1, 3, 3, 0, 2, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule